// File: doc/BRIEF.md
# Timestamp Fence Unit

This is a per-core unit that gives the core release-consistency fences while its stores run freely. Stores never wait on other cores' cached copies. When the shared cache acknowledges a store, the acknowledgement carries the latest time at which any other core's private copy of that address will expire. The unit keeps two things: a count of stores that have been issued but not yet acknowledged, and the largest expiry time seen since the last fence.

When the core asks for a fence, the unit holds it until two conditions are met. Every earlier store must have been acknowledged, and the chip-wide synchronized time must have reached the recorded maximum. At that point every earlier write has dropped out of all other private caches and is globally visible. The unit then signals completion and clears the recorded maximum to zero. Ordering comes entirely from comparing timestamps against the shared time. No invalidation acknowledgements are counted and no sharer lists are drained.

Top module: `ts_fence_unit`

## Requirements
- R1: After reset, `fence_done` and `fence_busy` are 0, no store is counted as in flight and the recorded expiry maximum is 0. A fence requested right after reset completes in the next cycle, even if an acknowledgement with a large expiry arrived before the reset.
- R2: If no store has been issued since the last fence, a fence request sampled at a clock edge raises `fence_done` for the cycle that follows that edge, and `fence_busy` stays 0.
- R3: The in-flight count rises by one for each cycle with `st_issue` high and falls by one for each cycle with `st_ack` high. A fence is not released while the count sampled at the edge is nonzero.
- R4: A fence is not released while `global_time` is below the recorded maximum expiry.
- R5: The recorded maximum is the largest `st_ack_expiry` since the last release. A later acknowledgement with a smaller expiry does not lower it.
- R6: A cycle with both `st_issue` and `st_ack` high leaves the in-flight count unchanged.
- R7: On release the recorded maximum is cleared to 0. A following fence with no new stores completes in one cycle even when `global_time` is below the earlier maximum.
- R8: `fence_busy` is 1 from the edge after a fence request that cannot be released at once until the edge where the fence is released. `fence_done` is a pulse in the cycle after that release edge. The two are never high together.
- R9: A fence request while `fence_busy` is 1 is ignored: the pending fence produces exactly one `fence_done` pulse.
- R10: Release is allowed when `global_time` equals the recorded maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_issue | input | 1 | The core issued one store this cycle |
| st_ack | input | 1 | One store acknowledgement arrives this cycle |
| st_ack_expiry | input | TS_W | Latest expiry of other cores' copies of the acknowledged address |
| global_time | input | TS_W | Synchronized chip-wide time |
| fence_req | input | 1 | The core requests a fence (one-cycle pulse) |
| fence_busy | output | 1 | A fence is waiting |
| fence_done | output | 1 | One-cycle pulse: the fence has completed |

## Verification
The bench drives a cycle table covering several situations:
- Acknowledgements arrive with falling expiries, which separates a running maximum from a unit that keeps only the last value.
- The time is held one below the maximum and then moved to exactly the maximum, which exposes an off-by-one in the comparison.
- An issue and an acknowledgement arrive in the same cycle.
- An acknowledgement arrives in the fence's own waiting cycle, which shows whether the release looks at the count before or after that edge.
- A repeated request is made while a fence is waiting, together with back-to-back fences after a large expiry, which shows whether the maximum is cleared.

A reset in the middle of traffic confirms that the state left behind by earlier stores and acknowledgements is discarded.

// File: rtl/ts_fence_pkg.sv
package ts_fence_pkg;
  typedef enum logic [0:0] {FS_IDLE = 1'b0, FS_WAIT = 1'b1} fence_state_e;
endpackage

// File: rtl/ts_store_tracker.sv
module ts_store_tracker #(
  parameter int unsigned MAX_OUT = 64,
  localparam int unsigned CNT_W = $clog2(MAX_OUT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             ack,
  output logic [CNT_W-1:0] count,
  output logic             drained
);
  // Net change of the in-flight count for one cycle.
  function automatic logic [CNT_W-1:0] next_count(logic [CNT_W-1:0] cur, logic inc, logic dec);
    if (inc && !dec) return cur + 1'b1;
    if (dec && !inc) return cur - 1'b1;
    return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= next_count(count, issue, ack);
  end

  assign drained = (count == '0);
endmodule

// File: rtl/ts_expiry_max.sv
module ts_expiry_max #(
  parameter int unsigned TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ack,
  input  logic [TS_W-1:0] expiry,
  input  logic            clear,
  output logic [TS_W-1:0] max_q
);
  function automatic logic [TS_W-1:0] ts_max(logic [TS_W-1:0] a, logic [TS_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     max_q <= '0;
    else if (clear) max_q <= '0;
    else if (ack)   max_q <= ts_max(max_q, expiry);
  end
endmodule

// File: rtl/ts_fence_ctrl.sv
module ts_fence_ctrl
  import ts_fence_pkg::*;
#(
  parameter int unsigned TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fence_req,
  input  logic            drained,
  input  logic [TS_W-1:0] global_time,
  input  logic [TS_W-1:0] max_exp,
  output logic            release_evt,
  output logic            fence_busy,
  output logic            fence_done
);
  fence_state_e state_q;
  logic         active;

  // The shared time has passed every expiry recorded so far.
  function automatic logic ts_reached(logic [TS_W-1:0] now, logic [TS_W-1:0] limit);
    return now >= limit;
  endfunction

  assign active      = fence_req || (state_q == FS_WAIT);
  assign release_evt = active && drained && ts_reached(global_time, max_exp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= FS_IDLE;
      fence_done <= 1'b0;
    end else begin
      fence_done <= release_evt;
      if (release_evt)  state_q <= FS_IDLE;
      else if (active)  state_q <= FS_WAIT;
    end
  end

  assign fence_busy = (state_q == FS_WAIT);
endmodule

// File: rtl/ts_fence_unit.sv
module ts_fence_unit #(
  parameter int unsigned TS_W    = 32,
  parameter int unsigned MAX_OUT = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            st_issue,
  input  logic            st_ack,
  input  logic [TS_W-1:0] st_ack_expiry,
  input  logic [TS_W-1:0] global_time,
  input  logic            fence_req,
  output logic            fence_busy,
  output logic            fence_done
);
  localparam int unsigned CNT_W = $clog2(MAX_OUT + 1);

  logic [CNT_W-1:0] inflight;
  logic             drained;
  logic [TS_W-1:0]  max_exp;
  logic             release_evt;

  ts_store_tracker #(.MAX_OUT(MAX_OUT)) u_track (
    .clk(clk), .rst_n(rst_n), .issue(st_issue), .ack(st_ack),
    .count(inflight), .drained(drained)
  );

  ts_expiry_max #(.TS_W(TS_W)) u_max (
    .clk(clk), .rst_n(rst_n), .ack(st_ack), .expiry(st_ack_expiry),
    .clear(release_evt), .max_q(max_exp)
  );

  ts_fence_ctrl #(.TS_W(TS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fence_req(fence_req), .drained(drained),
    .global_time(global_time), .max_exp(max_exp), .release_evt(release_evt),
    .fence_busy(fence_busy), .fence_done(fence_done)
  );
endmodule

// File: rtl/ts_fence_checker.sv
module ts_fence_checker #(
  parameter int unsigned TS_W    = 32,
  parameter int unsigned MAX_OUT = 64,
  localparam int unsigned CNT_W = $clog2(MAX_OUT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             st_issue,
  input logic             st_ack,
  input logic [TS_W-1:0]  st_ack_expiry,
  input logic [TS_W-1:0]  global_time,
  input logic             fence_busy,
  input logic             fence_done,
  input logic [CNT_W-1:0] inflight,
  input logic [TS_W-1:0]  max_exp,
  input logic             release_evt
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_issue && !st_ack) |-> (inflight != CNT_W'(MAX_OUT)));  // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ack && !st_issue) |-> (inflight != '0));  // R3
  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    fence_done |-> ($past(inflight) == '0));  // R3
  AST_DONE_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    fence_done |-> ($past(global_time) >= $past(max_exp)));  // R4
  AST_MAX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ack && !release_evt) |=> (max_exp >= $past(st_ack_expiry)));  // R5
  AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_issue && st_ack) |=> $stable(inflight));  // R6
  AST_MAX_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    fence_done |-> (max_exp == '0));  // R7
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fence_busy && fence_done));  // R8
endmodule

bind ts_fence_unit ts_fence_checker #(.TS_W(TS_W), .MAX_OUT(MAX_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_issue(st_issue), .st_ack(st_ack),
  .st_ack_expiry(st_ack_expiry), .global_time(global_time),
  .fence_busy(fence_busy), .fence_done(fence_done), .inflight(inflight),
  .max_exp(max_exp), .release_evt(release_evt)
);

// File: tb/tb_ts_fence_unit.sv
`timescale 1ns/1ps
module tb_ts_fence_unit;
  localparam int unsigned TS_W = 32;
  localparam int NV = 22;

  logic clk = 1'b0;
  logic rst_n;
  logic st_issue, st_ack, fence_req;
  logic [TS_W-1:0] st_ack_expiry, global_time;
  logic fence_busy, fence_done;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  ts_fence_unit #(.TS_W(TS_W), .MAX_OUT(64)) dut (
    .clk(clk), .rst_n(rst_n), .st_issue(st_issue), .st_ack(st_ack),
    .st_ack_expiry(st_ack_expiry), .global_time(global_time),
    .fence_req(fence_req), .fence_busy(fence_busy), .fence_done(fence_done)
  );

  // Row: issue, ack, expiry[15:0], time[15:0], fence_req, exp_done, exp_busy
  localparam logic [36:0] VEC [NV] = '{
    {1'b0,1'b0,16'd0,  16'd0,  1'b0,1'b0,1'b0},  // 0 idle
    {1'b1,1'b0,16'd0,  16'd0,  1'b0,1'b0,1'b0},  // 1 issue
    {1'b1,1'b0,16'd0,  16'd0,  1'b0,1'b0,1'b0},  // 2 issue
    {1'b0,1'b1,16'd50, 16'd10, 1'b0,1'b0,1'b0},  // 3 ack 50
    {1'b0,1'b1,16'd30, 16'd10, 1'b0,1'b0,1'b0},  // 4 ack 30, max stays 50 R5
    {1'b0,1'b0,16'd0,  16'd20, 1'b1,1'b0,1'b1},  // 5 fence, time short R4
    {1'b0,1'b0,16'd0,  16'd49, 1'b0,1'b0,1'b1},  // 6 one below max R4
    {1'b0,1'b0,16'd0,  16'd50, 1'b0,1'b1,1'b0},  // 7 equal releases R10
    {1'b0,1'b0,16'd0,  16'd51, 1'b0,1'b0,1'b0},  // 8 pulse ends R8
    {1'b0,1'b0,16'd0,  16'd0,  1'b1,1'b1,1'b0},  // 9 cleared max R7 R2
    {1'b1,1'b0,16'd0,  16'd0,  1'b0,1'b0,1'b0},  // 10 issue
    {1'b1,1'b1,16'd5,  16'd0,  1'b0,1'b0,1'b0},  // 11 issue+ack R6
    {1'b0,1'b0,16'd0,  16'd5,  1'b1,1'b0,1'b1},  // 12 still one in flight R3
    {1'b0,1'b0,16'd0,  16'd5,  1'b0,1'b0,1'b1},  // 13 R6 count held
    {1'b0,1'b1,16'd3,  16'd5,  1'b0,1'b0,1'b1},  // 14 ack in wait cycle R3
    {1'b0,1'b0,16'd0,  16'd5,  1'b0,1'b1,1'b0},  // 15 release
    {1'b1,1'b0,16'd0,  16'd100,1'b0,1'b0,1'b0},  // 16 issue
    {1'b0,1'b1,16'd120,16'd100,1'b0,1'b0,1'b0},  // 17 ack 120
    {1'b0,1'b0,16'd0,  16'd100,1'b1,1'b0,1'b1},  // 18 fence waits
    {1'b0,1'b0,16'd0,  16'd110,1'b1,1'b0,1'b1},  // 19 extra request R9
    {1'b0,1'b0,16'd0,  16'd120,1'b0,1'b1,1'b0},  // 20 release
    {1'b0,1'b0,16'd0,  16'd121,1'b0,1'b0,1'b0}   // 21 no second pulse R9
  };

  function automatic string req_of(int i);
    case (i)
      4: return "R5";
      5, 6: return "R4";
      7: return "R10";
      8: return "R8";
      9: return "R7";
      11, 13: return "R6";
      12, 14, 15: return "R3";
      19, 20, 21: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic drive(logic iss, logic ack, int unsigned ex, int unsigned t, logic fr);
    st_issue = iss; st_ack = ack; st_ack_expiry = TS_W'(ex);
    global_time = TS_W'(t); fence_req = fr;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0);
    repeat (3) tick();
    check("R1", "done after reset", fence_done, 1'b0);
    check("R1", "busy after reset", fence_busy, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][36], VEC[i][35], 32'(VEC[i][34:19]), 32'(VEC[i][18:3]), VEC[i][2]);
      tick();
      check(req_of(i), $sformatf("vec %0d done", i), fence_done, VEC[i][1]);
      check(req_of(i), $sformatf("vec %0d busy", i), fence_busy, VEC[i][0]);
    end

    // R1: reset in the middle of traffic discards count and maximum
    drive(1, 0, 0, 0, 0); tick();
    drive(1, 1, 1000, 0, 0); tick();
    drive(0, 0, 0, 0, 0);
    rst_n = 1'b0; tick(); tick();
    check("R1", "done in reset", fence_done, 1'b0);
    rst_n = 1'b1;
    drive(0, 0, 0, 0, 1); tick();
    check("R1", "fence after mid reset", fence_done, 1'b1);
    check("R2", "no busy on clean fence", fence_busy, 1'b0);

    // R2: back-to-back clean fences
    drive(0, 0, 0, 7, 1); tick();
    check("R2", "second clean fence", fence_done, 1'b1);
    drive(0, 0, 0, 7, 0); tick();
    check("R8", "pulse drops", fence_done, 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule